// File: doc/BRIEF.md
# Six-Pin Bidirectional GPIO Port

This block is the general-purpose I/O port of a small microcontroller. It has six pins. Each pin can be an input or an output, and one pin is always an input. Software reaches the port through a simple register bus: an address, a write strobe, write data, a per-bit write mask and combinational read data. There are five registers: the data register, the direction register, the weak pull-up enables, the analog-select mask and a control register.

Pad levels pass through a synchronizer before they can be read. Reading the data register returns those synchronized levels, not the output latch. Two conditions force a pin to read as zero: its analog-select bit is set, or, for the input-only pin, the reset-pin enable input is high. A data write is read-modify-write. Bits selected by the write mask take the write data. Every other latch bit is refilled from the value the pin currently reads. The block drives output enable, output value and an effective pull-up enable to each pad model.

Top module: `gpio6_port`

## Requirements
- R1: Register addresses are: 0 data, 1 direction, 2 pull-up enables, 3 analog-select, 4 control (bit 0 is the global pull-up disable). Addresses 5 to 7 read as 0. Bits 7:6 of every read are 0.
- R2: After a synchronous active-low reset, the direction register reads 0x3F, the analog-select and pull-up registers read 0x00, and the control register reads 0x01.
- R3: A direction bit of 1 turns the pin's driver off (pad_oe low). A direction bit of 0 sets pad_oe high, and the pin then shows the output latch on pad_out.
- R4: Pin 3 is input-only. Its direction bit reads 1 whatever is written, and pad_oe[3] is never high.
- R5: The data register returns each pad level two clock edges after that level appears on pad_in.
- R6: A write to address 0 loads the latch. A bit whose wmask bit is 1 takes wdata. A bit whose wmask bit is 0 takes the value the data register reads in that cycle. The new latch is visible on pad_out after the write edge.
- R7: A pin whose analog-select bit is 1 reads as 0 at address 0, including when its value is used as a read-modify-write refill. Its direction bit still controls pad_oe.
- R8: While reset_pin_en is 1, pin 3 reads as 0 at address 0.
- R9: pull_en[i] is 1 only when pull-up bit i is 1, direction bit i is 1 (input) and the global disable is 0. Pin 3 has no pull-up: its pull-up bit reads 0 and pull_en[3] stays 0.
- R10: While the global pull-up disable bit is 1, all pull_en outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_wr_en | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_wmask | input | 6 | Data-register write mask; a 0 bit is refilled from the pin |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| reset_pin_en | input | 1 | Pin 3 is used as the reset pin and reads 0 |
| pad_in | input | 6 | Raw pad input levels |
| pad_oe | output | 6 | Pad driver enable |
| pad_out | output | 6 | Output latch value to the pads |
| pull_en | output | 6 | Effective weak pull-up enable per pad |

## Verification
Register writes appear on bus_rdata, pad_oe, pad_out and pull_en right after the write edge, because reads are combinational from the registers. A pad level reaches the data register only after two edges. The bench's reference model keeps its own two-entry pipeline of pad values, so the expected read value comes from pad_in as it was two edges earlier. The bench drives inputs on the falling edge and compares every output against the model on the next falling edge. Each comparison therefore sees exactly one rising edge of state change.

// File: rtl/gpio6_pkg.sv
// Package: shared bus constants for the six-pin GPIO port.
// Assumes a fixed 3-bit register address and an 8-bit data bus.
package gpio6_pkg;
    localparam int BUS_W  = 8;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] ADDR_DATA = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_DIR  = 3'd1;
    localparam logic [ADDR_W-1:0] ADDR_PULL = 3'd2;
    localparam logic [ADDR_W-1:0] ADDR_ANA  = 3'd3;
    localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd4;
endpackage

// File: rtl/gpio6_sync.sv
// Module: multi-stage synchronizer for the pad input levels.
// Assumes the pads are asynchronous to clk. STAGES must be at least 1.
module gpio6_sync #(
    parameter int WIDTH  = 6,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    // Shift the pad levels through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) stage_q[k] <= '0;
        end else begin
            stage_q[0] <= d;
            for (int k = 1; k < STAGES; k++) stage_q[k] <= stage_q[k-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio6_pin_view.sv
// Module: the per-pin value software sees when it reads the data register.
// Analog-selected pins read 0. The input-only pin also reads 0 while it
// serves as the reset pin.
module gpio6_pin_view #(
    parameter int NUM_PINS    = 6,
    parameter int IN_ONLY_PIN = 3
) (
    input  logic [NUM_PINS-1:0] sync_lvl,
    input  logic [NUM_PINS-1:0] ana_sel,
    input  logic                reset_pin_en,
    output logic [NUM_PINS-1:0] view
);
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        if (i == IN_ONLY_PIN) begin : g_rst_pin
            // Input-only pin: also masked while used as the reset pin.
            assign view[i] = sync_lvl[i] & ~ana_sel[i] & ~reset_pin_en;
        end else begin : g_plain
            // Ordinary pin: masked only by analog select.
            assign view[i] = sync_lvl[i] & ~ana_sel[i];
        end
    end
endmodule

// File: rtl/gpio6_regs.sv
// Module: the port's register file and read multiplexer.
// The output latch has no reset; its value stays undefined until the
// first data write. The input-only pin's direction bit is held at 1 and
// its pull-up bit is held at 0.
module gpio6_regs
    import gpio6_pkg::*;
#(
    parameter int NUM_PINS    = 6,
    parameter int IN_ONLY_PIN = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [BUS_W-1:0]    wdata,
    input  logic [NUM_PINS-1:0] wmask,
    input  logic [NUM_PINS-1:0] pin_view,
    output logic [NUM_PINS-1:0] latch_q,
    output logic [NUM_PINS-1:0] dir_q,
    output logic [NUM_PINS-1:0] pull_q,
    output logic [NUM_PINS-1:0] ana_q,
    output logic                pu_dis_q,
    output logic [BUS_W-1:0]    rdata
);
    localparam logic [NUM_PINS-1:0] IN_ONLY_MASK =
        {{(NUM_PINS-1){1'b0}}, 1'b1} << IN_ONLY_PIN;

    logic [NUM_PINS-1:0] wpins;
    logic                hit_data, hit_dir, hit_pull, hit_ana, hit_ctrl;

    assign wpins    = wdata[NUM_PINS-1:0];
    assign hit_data = wr_en && (addr == ADDR_DATA);
    assign hit_dir  = wr_en && (addr == ADDR_DIR);
    assign hit_pull = wr_en && (addr == ADDR_PULL);
    assign hit_ana  = wr_en && (addr == ADDR_ANA);
    assign hit_ctrl = wr_en && (addr == ADDR_CTRL);

    // Output latch: masked bits take wdata, the rest are refilled from the pins.
    always_ff @(posedge clk) begin
        if (hit_data) latch_q <= (wpins & wmask) | (pin_view & ~wmask);
    end

    // Direction, pull-up, analog and control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q    <= '1;
            pull_q   <= '0;
            ana_q    <= '0;
            pu_dis_q <= 1'b1;
        end else begin
            if (hit_dir)  dir_q    <= wpins | IN_ONLY_MASK;
            if (hit_pull) pull_q   <= wpins & ~IN_ONLY_MASK;
            if (hit_ana)  ana_q    <= wpins;
            if (hit_ctrl) pu_dis_q <= wdata[0];
        end
    end

    // Read multiplexer; unmapped addresses and unused bits read 0.
    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_DATA: rdata[NUM_PINS-1:0] = pin_view;
            ADDR_DIR:  rdata[NUM_PINS-1:0] = dir_q;
            ADDR_PULL: rdata[NUM_PINS-1:0] = pull_q;
            ADDR_ANA:  rdata[NUM_PINS-1:0] = ana_q;
            ADDR_CTRL: rdata[0]            = pu_dis_q;
            default:   rdata               = '0;
        endcase
    end
endmodule

// File: rtl/gpio6_pad_ctrl.sv
// Module: per-pad driver enable and effective weak pull-up.
// A pull-up is active only on an input pin and only while the global
// disable is clear. The input-only pin is never driven and has no pull-up.
module gpio6_pad_ctrl #(
    parameter int NUM_PINS    = 6,
    parameter int IN_ONLY_PIN = 3
) (
    input  logic [NUM_PINS-1:0] dir_q,
    input  logic [NUM_PINS-1:0] pull_q,
    input  logic                pu_dis,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic [NUM_PINS-1:0] pull_en
);
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pad
        if (i == IN_ONLY_PIN) begin : g_in_only
            // Input-only pin: no driver, no pull-up.
            assign pad_oe[i]  = 1'b0;
            assign pull_en[i] = 1'b0;
        end else begin : g_bidir
            // Bidirectional pin: drive when the direction bit is 0.
            assign pad_oe[i]  = ~dir_q[i];
            assign pull_en[i] = pull_q[i] & dir_q[i] & ~pu_dis;
        end
    end
endmodule

// File: rtl/gpio6_port.sv
// Module: top of the six-pin GPIO port.
// Connects the synchronizer, the read view, the register file and the pad
// controls. Assumes NUM_PINS < BUS_W and IN_ONLY_PIN < NUM_PINS.
module gpio6_port
    import gpio6_pkg::*;
#(
    parameter int NUM_PINS    = 6,
    parameter int IN_ONLY_PIN = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr_en,
    input  logic [BUS_W-1:0]    bus_wdata,
    input  logic [NUM_PINS-1:0] bus_wmask,
    output logic [BUS_W-1:0]    bus_rdata,
    input  logic                reset_pin_en,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pull_en
);
    logic [NUM_PINS-1:0] sync_lvl;
    logic [NUM_PINS-1:0] pin_view;
    logic [NUM_PINS-1:0] dir_q;
    logic [NUM_PINS-1:0] pull_q;
    logic [NUM_PINS-1:0] ana_q;
    logic                pu_dis_q;

    gpio6_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (sync_lvl)
    );

    gpio6_pin_view #(.NUM_PINS(NUM_PINS), .IN_ONLY_PIN(IN_ONLY_PIN)) u_view (
        .sync_lvl     (sync_lvl),
        .ana_sel      (ana_q),
        .reset_pin_en (reset_pin_en),
        .view         (pin_view)
    );

    gpio6_regs #(.NUM_PINS(NUM_PINS), .IN_ONLY_PIN(IN_ONLY_PIN)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_wr_en),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .wmask    (bus_wmask),
        .pin_view (pin_view),
        .latch_q  (pad_out),
        .dir_q    (dir_q),
        .pull_q   (pull_q),
        .ana_q    (ana_q),
        .pu_dis_q (pu_dis_q),
        .rdata    (bus_rdata)
    );

    gpio6_pad_ctrl #(.NUM_PINS(NUM_PINS), .IN_ONLY_PIN(IN_ONLY_PIN)) u_pad (
        .dir_q   (dir_q),
        .pull_q  (pull_q),
        .pu_dis  (pu_dis_q),
        .pad_oe  (pad_oe),
        .pull_en (pull_en)
    );
endmodule

// File: rtl/gpio6_port_checker.sv
// Module: property checker for gpio6_port, attached with bind below.
// Observes ports and the analog mask and pull-up disable registers.
module gpio6_port_checker
    import gpio6_pkg::*;
#(
    parameter int NUM_PINS    = 6,
    parameter int IN_ONLY_PIN = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                bus_wr_en,
    input logic [BUS_W-1:0]    bus_wdata,
    input logic [NUM_PINS-1:0] bus_wmask,
    input logic [BUS_W-1:0]    bus_rdata,
    input logic                reset_pin_en,
    input logic [NUM_PINS-1:0] pad_oe,
    input logic [NUM_PINS-1:0] pad_out,
    input logic [NUM_PINS-1:0] pull_en,
    input logic [NUM_PINS-1:0] ana_q,
    input logic                pu_dis_q
);
    localparam int P = (IN_ONLY_PIN == 0) ? 1 : 0;

    a_r1_upper_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[BUS_W-1:NUM_PINS] == '0);

    a_r3_oe_follows_dir: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_addr == ADDR_DIR) |=> (pad_oe[P] == !$past(bus_wdata[P])));

    a_r4_in_only_undriven: assert property (@(posedge clk) disable iff (!rst_n)
        !pad_oe[IN_ONLY_PIN]);

    a_r4_dir_reads_input: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_DIR) |-> bus_rdata[IN_ONLY_PIN]);

    a_r6_masked_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_addr == ADDR_DATA && bus_wmask[P])
            |=> (pad_out[P] == $past(bus_wdata[P])));

    a_r7_analog_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_DATA) |-> ((bus_rdata[NUM_PINS-1:0] & ana_q) == '0));

    a_r8_reset_pin_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reset_pin_en && bus_addr == ADDR_DATA) |-> !bus_rdata[IN_ONLY_PIN]);

    a_r9_no_pull_on_output: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & pull_en) == '0);

    a_r10_global_disable: assert property (@(posedge clk) disable iff (!rst_n)
        pu_dis_q |-> (pull_en == '0));
endmodule

bind gpio6_port gpio6_port_checker #(
    .NUM_PINS    (NUM_PINS),
    .IN_ONLY_PIN (IN_ONLY_PIN)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_wr_en    (bus_wr_en),
    .bus_wdata    (bus_wdata),
    .bus_wmask    (bus_wmask),
    .bus_rdata    (bus_rdata),
    .reset_pin_en (reset_pin_en),
    .pad_oe       (pad_oe),
    .pad_out      (pad_out),
    .pull_en      (pull_en),
    .ana_q        (ana_q),
    .pu_dis_q     (pu_dis_q)
);

// File: tb/gpio6_port_test.sv
`timescale 1ns/1ps
// Bench: a behavioural reference model compared on every falling edge.
module gpio6_port_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr_en = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [5:0] bus_wmask = '0;
    logic [7:0] bus_rdata;
    logic       reset_pin_en = 1'b0;
    logic [5:0] pad_in = '0;
    logic [5:0] pad_oe, pad_out, pull_en;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    always #10 clk = ~clk;

    gpio6_port uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
        .bus_wdata(bus_wdata), .bus_wmask(bus_wmask), .bus_rdata(bus_rdata),
        .reset_pin_en(reset_pin_en), .pad_in(pad_in), .pad_oe(pad_oe),
        .pad_out(pad_out), .pull_en(pull_en)
    );

    // Reference model state.
    logic [5:0] m_s1, m_s2, m_dir, m_pull, m_ana, m_latch, m_known;
    logic       m_dis;
    initial begin
        m_s1 = 0; m_s2 = 0; m_dir = 6'h3F; m_pull = 0; m_ana = 0;
        m_latch = 0; m_known = 0; m_dis = 1'b1;
    end

    function automatic logic [5:0] m_view();
        logic [5:0] v;
        v = m_s2 & ~m_ana;
        if (reset_pin_en) v[3] = 1'b0;
        return v;
    endfunction

    function automatic logic [7:0] m_read(input logic [2:0] a);
        case (a)
            3'd0: return {2'b00, m_view()};
            3'd1: return {2'b00, m_dir};
            3'd2: return {2'b00, m_pull};
            3'd3: return {2'b00, m_ana};
            3'd4: return {7'd0, m_dis};
            default: return 8'h00;
        endcase
    endfunction

    // Model update at each rising edge.
    always @(posedge clk) begin
        logic [5:0] v;
        v = m_view();
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_dir = 6'h3F; m_pull = 0; m_ana = 0; m_dis = 1'b1;
        end else begin
            if (bus_wr_en) begin
                case (bus_addr)
                    3'd0: begin
                        m_latch = (bus_wdata[5:0] & bus_wmask) | (v & ~bus_wmask);
                        m_known = 6'h3F;
                    end
                    3'd1: m_dir  = bus_wdata[5:0] | 6'h08;
                    3'd2: m_pull = bus_wdata[5:0] & 6'h37;
                    3'd3: m_ana  = bus_wdata[5:0];
                    3'd4: m_dis  = bus_wdata[0];
                    default: ;
                endcase
            end
            m_s2 = m_s1;
            m_s1 = pad_in;
        end
    end

    task automatic check(input string what, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h at %0t", what, got, exp, $time);
        end
    endtask

    task automatic compare_all();
        check("R1/R5/R7/R8 bus_rdata", bus_rdata, m_read(bus_addr));
        check("R3/R4 pad_oe", {2'b00, pad_oe}, {2'b00, ~m_dir & 6'h37});
        check("R6 pad_out", {2'b00, pad_out & m_known}, {2'b00, m_latch & m_known});
        check("R9/R10 pull_en", {2'b00, pull_en},
              {2'b00, m_pull & m_dir & {6{~m_dis}} & 6'h37});
    endtask

    task automatic step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d, input logic [5:0] m);
        bus_addr = a; bus_wdata = d; bus_wmask = m; bus_wr_en = 1'b1;
        step();
        bus_wr_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        // R2: reset state read through the bus.
        bus_addr = 3'd1; #1 check("R2 dir reset", bus_rdata, 8'h3F);
        bus_addr = 3'd2; #1 check("R2 pull reset", bus_rdata, 8'h00);
        bus_addr = 3'd3; #1 check("R2 analog reset", bus_rdata, 8'h00);
        bus_addr = 3'd4; #1 check("R2 ctrl reset", bus_rdata, 8'h01);
        bus_addr = 3'd6; #1 check("R1 unmapped reads 0", bus_rdata, 8'h00);
        check("R10 pull_en off at reset", {2'b00, pull_en}, 8'h00);

        // R4: writing 0 to direction still leaves pin 3 an input.
        wr(3'd1, 8'h00, 6'h3F);
        bus_addr = 3'd1; #1 check("R4 dir pin3 reads 1", bus_rdata, 8'h08);
        check("R3 all drivers on but pin3", {2'b00, pad_oe}, 8'h37);

        // R5: level appears after two edges.
        pad_in = 6'h2A; bus_addr = 3'd0;
        step(); step();
        check("R5 data after two edges", bus_rdata, 8'h2A);

        // R6: masked write refills from pins.
        wr(3'd0, 8'h05, 6'h07);
        check("R6 rmw latch", {2'b00, pad_out}, 8'h2D);

        // R7: analog pin reads 0 and refills as 0; drivers still follow dir.
        wr(3'd3, 8'h20, 6'h3F);
        bus_addr = 3'd0; #1 check("R7 analog pin reads 0", bus_rdata, 8'h0A);
        check("R7 analog keeps direction", {2'b00, pad_oe}, 8'h37);
        wr(3'd0, 8'h00, 6'h00);
        check("R7 analog refill zero", {2'b00, pad_out}, 8'h0A);
        wr(3'd3, 8'h00, 6'h3F);

        // R8: reset pin masks pin 3.
        pad_in = 6'h08; step(); step();
        bus_addr = 3'd0; #1 check("R8 pin3 visible", bus_rdata, 8'h08);
        reset_pin_en = 1'b1; #1 check("R8 pin3 masked", bus_rdata, 8'h00);
        reset_pin_en = 1'b0;

        // R9/R10: pull-ups gated by direction and global disable.
        wr(3'd1, 8'h3C, 6'h3F);
        wr(3'd2, 8'h3F, 6'h3F);
        bus_addr = 3'd2; #1 check("R9 pin3 pull bit reads 0", bus_rdata, 8'h37);
        check("R10 disabled pulls", {2'b00, pull_en}, 8'h00);
        wr(3'd4, 8'h00, 6'h3F);
        check("R9 pull gated by direction", {2'b00, pull_en}, 8'h34);

        // Random traffic, one mid-run reset.
        for (int c = 0; c < 3000; c++) begin
            bus_addr     = 3'($urandom_range(0, 5));
            bus_wr_en    = ($urandom_range(0, 2) == 0);
            bus_wdata    = 8'($urandom);
            bus_wmask    = 6'($urandom);
            if ($urandom_range(0, 1) == 0) pad_in = 6'($urandom);
            if ($urandom_range(0, 15) == 0) reset_pin_en = ~reset_pin_en;
            rst_n = !(c == 1500);
            step();
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog R1 actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule